// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block moves up to eight bits at a time between an 8-bit data register and a serial memory. The memory sits on a three-wire bus made of a serial clock, one bidirectional data line and a chip select. Firmware drives the chip select on a general-purpose pin and builds each memory command out of several short shift operations. Each operation starts when firmware writes the control word. That word gives the bit count, the direction, whether the data line is released after the last clock, and whether completion waits for the memory to report ready.

During a transfer the block produces SCK from the system clock through a programmable divider. SCK idles low. Outgoing data changes when SCK falls, and incoming data is sampled when SCK rises. A busy flag stays high for the whole operation, and a one-cycle completion pulse follows its falling edge.

A zero-count command issues no clocks. It only sets whether the data line is driven or released. Firmware uses it to take the line back after a read. With wait-for-ready, the end of a write is held back until the memory pulls the released data line high, which signals that its internal programming has finished.

Top module: `e3w_shifter`

## Requirements
- R1: After reset, busy, SCK, the data-line output enable and the completion pulse are all 0, and the data register holds 0.
- R2: The control word is laid out as follows: bits [3:0] are the count, bit 4 is read (1) or write (0), bit 5 is release-after-last-clock, and bit 6 is wait-for-ready. A control write with a nonzero count while idle makes busy read 1 from the next cycle.
- R3: A transfer issues exactly as many SCK pulses as the count. Counts above 8 act as 8. Each pulse is SCK_HALF system clocks low followed by SCK_HALF system clocks high, and SCK stays low whenever busy is 0.
- R4: In write mode, the data output always carries bit 7 of the data register, and the register shifts left with zero fill when SCK falls. The line therefore sends n bits MSB first, holds steady while SCK is high, and leaves the register equal to its old value shifted left by n.
- R5: In read mode, the data input is sampled as SCK rises and shifted into bit 0. After n bits the register equals (old value << n) | received bits, masked to 8 bits, with the first received bit in position n-1.
- R6: From the start of a transfer, the output enable is 1 for a write and 0 for a read. At the last rising SCK edge it becomes 0 if release is set and 1 otherwise.
- R7: A zero-count command issues no SCK, leaves busy at 0 and gives no completion pulse. From the next cycle, the output enable equals the inverse of the release bit.
- R8: Busy falls at the end of the high phase of the last SCK pulse. The completion pulse is high for exactly one cycle, in the first cycle busy reads 0.
- R9: With wait-for-ready and release both set, busy stays high after the last pulse until a 0-to-1 edge is seen on the data input. With release clear, wait-for-ready has no effect.
- R10: Control writes and data-register writes made while busy is 1 are ignored.
- R11: A data-register write while idle loads the written byte, which is then visible on the data-register output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 7 | Control word: count, direction, release, wait-for-ready |
| dataWe | input | 1 | Data register write strobe |
| dataWdata | input | 8 | Byte to load into the data register |
| dataReg | output | 8 | Data register contents |
| busy | output | 1 | High while a transfer or ready-wait is in progress |
| doneIrq | output | 1 | One-cycle pulse when busy falls |
| sck | output | 1 | Serial clock, idles low |
| sdOut | output | 1 | Data line output value |
| sdOe | output | 1 | Data line output enable (0 = released) |
| sdIn | input | 1 | Data line input value |

## Verification
The hardest state to reach from the ports is the ready-wait after a write. It only exists when wait-for-ready and release are both set and the count is nonzero. It ends only on a rising edge of the data input, so a memory that idles high would never let it finish. The bench sweeps every count, direction, release and wait combination while it models the memory's data line. It holds the line low after the last clock, confirms that busy persists and that no completion pulse appears over several cycles, and then raises the line. It expects busy to fall with the pulse in the following cycle.

// File: rtl/e3w_pkg.sv
package e3w_pkg;
  parameter int DATA_W = 8;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int CTRL_W = CNT_W + 3;

  typedef struct packed {
    logic             waitRdy;
    logic             relLine;
    logic             rdDir;
    logic [CNT_W-1:0] count;
  } ctrlWord_t;

  typedef struct packed {
    logic sample;
    logic shift;
    logic oeSet;
    logic oeVal;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } shState_t;
endpackage

// File: rtl/e3w_ctrl.sv
module e3w_ctrl
  import e3w_pkg::*;
#(
  parameter int SCK_HALF = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              sdIn,
  output logic              busy,
  output logic              sck,
  output logic              doneIrq,
  output dpStrobe_t         strobe
);
  localparam int DIV_W = $clog2(SCK_HALF + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);

  shState_t         state, nextState;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic             rdQ, relQ, waitQ;
  logic             sdInPrev;
  ctrlWord_t        cmd;
  logic             start, halfEnd, lastBit, sdRise;
  logic [CNT_W-1:0] cmdCount;

  assign cmd      = ctrlWord_t'(ctrlWdata);
  assign cmdCount = (cmd.count > CNT_MAX) ? CNT_MAX : cmd.count;
  assign start    = ctrlWe && (state == ST_IDLE);
  assign halfEnd  = (divCnt == DIV_LAST);
  assign lastBit  = (bitsLeft == CNT_W'(1));
  assign sdRise   = sdIn && !sdInPrev;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.oeSet = 1'b1;
          if (cmdCount == '0) begin
            strobe.oeVal = !cmd.relLine;
          end else begin
            strobe.oeVal = !cmd.rdDir;
            nextState    = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (halfEnd) begin
          nextState     = ST_HIGH;
          strobe.sample = rdQ;
          if (lastBit) begin
            strobe.oeSet = 1'b1;
            strobe.oeVal = !relQ;
          end
        end
      end
      ST_HIGH: begin
        if (halfEnd) begin
          strobe.shift = !rdQ;
          if (!lastBit) nextState = ST_LOW;
          else if (waitQ && relQ) nextState = ST_WAIT;
          else nextState = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (sdRise) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitsLeft <= '0;
      rdQ      <= 1'b0;
      relQ     <= 1'b0;
      waitQ    <= 1'b0;
      sdInPrev <= 1'b0;
      sck      <= 1'b0;
      doneIrq  <= 1'b0;
    end else begin
      state    <= nextState;
      sdInPrev <= sdIn;
      sck      <= (nextState == ST_HIGH);
      doneIrq  <= busy && (nextState == ST_IDLE);
      if ((state == ST_LOW || state == ST_HIGH) && !halfEnd) divCnt <= divCnt + DIV_W'(1);
      else divCnt <= '0;
      if (start) begin
        bitsLeft <= cmdCount;
        rdQ      <= cmd.rdDir;
        relQ     <= cmd.relLine;
        waitQ    <= cmd.waitRdy;
      end else if (state == ST_HIGH && halfEnd) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
    end
  end

  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW || state == ST_HIGH) |-> (bitsLeft >= CNT_W'(1) && bitsLeft <= CNT_MAX)); // R3
  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck); // R3
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && $past(busy))); // R8
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWe) |=> ($stable(rdQ) && $stable(relQ) && $stable(waitQ))); // R10
endmodule

// File: rtl/e3w_datapath.sv
module e3w_datapath
  import e3w_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWdata,
  input  dpStrobe_t         strobe,
  input  logic              sdIn,
  output logic [DATA_W-1:0] dataReg,
  output logic              sdOut,
  output logic              sdOe
);
  assign sdOut = dataReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      sdOe    <= 1'b0;
    end else begin
      if (dataWe && !busy) dataReg <= dataWdata;
      else if (strobe.sample) dataReg <= {dataReg[DATA_W-2:0], sdIn};
      else if (strobe.shift) dataReg <= {dataReg[DATA_W-2:0], 1'b0};
      if (strobe.oeSet) sdOe <= strobe.oeVal;
    end
  end

  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && busy && !strobe.sample && !strobe.shift) |=> $stable(dataReg)); // R10
endmodule

// File: rtl/e3w_shifter.sv
module e3w_shifter
  import e3w_pkg::*;
#(
  parameter int SCK_HALF = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWdata,
  output logic [DATA_W-1:0] dataReg,
  output logic              busy,
  output logic              doneIrq,
  output logic              sck,
  output logic              sdOut,
  output logic              sdOe,
  input  logic              sdIn
);
  dpStrobe_t strobe;

  e3w_ctrl #(.SCK_HALF(SCK_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .sdIn(sdIn),
    .busy(busy), .sck(sck), .doneIrq(doneIrq), .strobe(strobe)
  );

  e3w_datapath uData (
    .clk(clk), .rstN(rstN), .busy(busy), .dataWe(dataWe), .dataWdata(dataWdata),
    .strobe(strobe), .sdIn(sdIn), .dataReg(dataReg), .sdOut(sdOut), .sdOe(sdOe)
  );

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !busy && ctrlWdata[CNT_W-1:0] != '0) |=> busy); // R2
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !busy && ctrlWdata[CNT_W-1:0] == '0) |=> (!busy && !sck)); // R7
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(sdOut)); // R4
endmodule

// File: tb/sim_e3w_shifter.sv
module sim_e3w_shifter;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [6:0] ctrlWdata = '0;
  logic       dataWe = 1'b0;
  logic [7:0] dataWdata = '0;
  logic [7:0] dataReg;
  logic       busy, doneIrq, sck, sdOut, sdOe;
  logic       sdIn = 1'b0;

  int checks = 0;
  int failures = 0;
  int sckCount = 0;
  int highCycles = 0;
  int irqCount = 0;
  int rxIdx = -1;
  logic [7:0] rxPat = '0;
  logic [7:0] capBits = '0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  e3w_shifter #(.SCK_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .dataWe(dataWe), .dataWdata(dataWdata), .dataReg(dataReg), .busy(busy),
    .doneIrq(doneIrq), .sck(sck), .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn)
  );

  always @(posedge sck) begin
    sckCount = sckCount + 1;
    capBits  = {capBits[6:0], sdOut};
  end

  always @(posedge sck) begin
    #1;
    rxIdx = rxIdx - 1;
    sdIn  = (rxIdx >= 0) ? rxPat[rxIdx] : 1'b0;
  end

  always @(negedge clk) if (sck) highCycles = highCycles + 1;
  always @(posedge clk) if (doneIrq) irqCount = irqCount + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runXfer(input logic [7:0] data, input logic [6:0] cmd, input logic [7:0] rx);
    int n, rd, rel, wt, expData, expCap;
    n   = (cmd[3:0] > 8) ? 8 : int'(cmd[3:0]);
    rd  = cmd[4];
    rel = cmd[5];
    wt  = cmd[6];
    @(negedge clk); dataWe = 1'b1; dataWdata = data;
    @(negedge clk); dataWe = 1'b0;
    check(dataReg == data, "R11 data load", dataReg, data);
    sckCount = 0; highCycles = 0; irqCount = 0; capBits = '0;
    rxPat = rx; rxIdx = n - 1;
    sdIn  = (n > 0) ? rx[n-1] : 1'b0;
    ctrlWe = 1'b1; ctrlWdata = cmd;
    @(negedge clk); ctrlWe = 1'b0;
    if (n == 0) begin
      check(busy == 1'b0, "R7 zero count busy", busy, 0);
      check(sdOe == !rel, "R7 zero count drive", sdOe, !rel);
      repeat (10) @(negedge clk);
      check(sckCount == 0, "R7 zero count clocks", sckCount, 0);
      check(irqCount == 0, "R7 zero count irq", irqCount, 0);
      check(dataReg == data, "R7 zero count data", dataReg, data);
    end else begin
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check(sdOe == !rd, "R6 drive during transfer", sdOe, !rd);
      ctrlWe = 1'b1; ctrlWdata = 7'h01; dataWe = 1'b1; dataWdata = ~data;
      @(negedge clk); ctrlWe = 1'b0; dataWe = 1'b0;
      repeat (2 * HALF * n + 3) @(negedge clk);
      if (wt && rel) begin
        check(busy == 1'b1, "R9 held for ready", busy, 1);
        repeat (6) @(negedge clk);
        check(busy == 1'b1, "R9 still held", busy, 1);
        check(irqCount == 0, "R9 no irq while held", irqCount, 0);
        sdIn = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R9 release on rise", busy, 0);
        check(doneIrq == 1'b1, "R9 irq on release", doneIrq, 1);
        @(negedge clk);
        sdIn = 1'b0;
      end else begin
        check(busy == 1'b0, wt ? "R9 wait ignored" : "R8 busy falls", busy, 0);
      end
      check(irqCount == 1, "R8 single irq", irqCount, 1);
      check(sckCount == n, "R3 clock count", sckCount, n);
      check(highCycles == n * HALF, "R3 high time", highCycles, n * HALF);
      check(sdOe == !rel, "R6 drive after last edge", sdOe, !rel);
      if (rd) begin
        expData = ((int'(data) << n) | (int'(rx) & ((1 << n) - 1))) & 255;
        check(dataReg == expData, "R5 read result R10", dataReg, expData);
      end else begin
        expData = (int'(data) << n) & 255;
        expCap  = int'(data) >> (8 - n);
        check((int'(capBits) & ((1 << n) - 1)) == expCap, "R4 bits sent", capBits, expCap);
        check(dataReg == expData, "R4 shifted data R10", dataReg, expData);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && sck == 1'b0 && doneIrq == 1'b0, "R1 reset flags", {busy, sck, doneIrq}, 0);
    check(sdOe == 1'b0 && dataReg == 8'h00, "R1 reset data", {sdOe, dataReg}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 8; m++) begin
        runXfer(8'hA5 ^ 8'(c * 17 + m * 3), {m[2], m[1], m[0], c[3:0]}, 8'h3C ^ 8'(c * 7 + m * 29));
      end
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule